// File: doc/BRIEF.md
# Bus-Master DMA Channel Register Block

This block holds the control state of one disk channel's bus-master DMA engine. Software reaches it through a byte-addressed register port with an 8-byte window. The window holds three registers: a command register, a status register and a descriptor table pointer. When software sets the start/stop bit, the block sends a one-cycle start pulse to the attached device, together with the current descriptor pointer. When software clears that bit during a transfer, the block sends a one-cycle abort pulse. When the device reports completion, the block returns the channel to idle and raises the interrupt-status bit.

A two-state channel machine drives the start/stop behaviour. Its states are `CH_IDLE` and `CH_BUSY`, and it has three named transitions:
- **LAUNCH** goes from `CH_IDLE` to `CH_BUSY`. It needs a command write with bit 0 set and a device present.
- **HALT** goes from `CH_BUSY` to `CH_IDLE`. It needs a command write with bit 0 clear and a device present.
- **FINISH** goes from `CH_BUSY` to `CH_IDLE`. It happens on `dma_done`.

The command start/stop bit and the status active bit both show whether the machine is in `CH_BUSY`.

Bad write sizes do not stop the block. Start/stop requests made with no device attached do not stop it either. Both cases set the status error bit, which stays set until software clears it. Descriptor walking, data movement and the disk protocol are handled elsewhere.

Top module: `bmdma_regs`

## Requirements
- R1: After reset the block is in this state:
  - The command byte reads 0x00.
  - The status byte reads 0x60, with drive-capable bits 5 and 6 set.
  - The pointer reads 0.
  - No start or abort pulse is issued.
- R2: Only three writes are legal:
  - a 1-byte write to offset 0 (command);
  - a 1-byte write to offset 2 (status);
  - a 4-byte write to offset 4 (pointer).

  Any other write sets status bit 1 (error) and changes no other register. Size codes are 0 for 1 byte, 1 for 2 bytes, 2 for 4 bytes, and 3 is invalid.
- R3: The LAUNCH transition works as follows. In `CH_IDLE` with `dev_present` high, a command write with bit 0 = 1 raises `dma_start` for exactly one cycle, starting the cycle after the write. In that cycle `dma_start_ptr` holds the pointer value. Command bit 0 and status bit 0 (active) then read 1.
- R4: The HALT transition works as follows. In `CH_BUSY` with `dev_present` high, a command write with bit 0 = 0 raises `dma_abort` for exactly one cycle. Command bit 0 and status bit 0 then read 0.
- R5: Status bit 0 (active) is read-only: a status write never changes it.
- R6: Status bits 1 (error) and 2 (interrupt) are write-one-to-clear. Writing 0 to either bit leaves it unchanged. Status bits 7:3 store the written value.
- R7: The FINISH transition works as follows. `dma_done` clears command bit 0 and status bit 0 and sets status bit 2. In the same cycle it overrides a start/stop bit being written and a write-one-to-clear of bit 2.
- R8: A pointer write stores the written word with bits 1:0 forced to 0.
- R9: Reads never change state. A read of 1, 2 or 4 bytes returns the window bytes from the given offset upward, little-endian. Bytes 1 and 3 read 0, bytes past offset 7 read 0, and size code 3 reads 0.
- R10: With `dev_present` low, a command write that would launch or halt issues no pulse and leaves the channel state unchanged. It sets status bit 1 instead.
- R11: Command bits 7:1 always store the written value, in either state. `irq_pending` mirrors status bit 2, `acc_error` mirrors status bit 1, and `dma_active` mirrors status bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Register access this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0: 1 byte, 1: 2 bytes, 2: 4 bytes, 3: invalid |
| acc_offset | input | 3 | Byte offset in the window |
| acc_wdata | input | 32 | Write data, little-endian from the offset |
| acc_rdata | output | 32 | Read data (combinational) |
| dev_present | input | 1 | A device is attached to the channel |
| dma_done | input | 1 | Device completion pulse |
| dma_start | output | 1 | Start pulse to the device |
| dma_start_ptr | output | 32 | Descriptor pointer captured with the start pulse |
| dma_abort | output | 1 | Abort pulse to the device |
| dma_active | output | 1 | Channel is in `CH_BUSY` |
| irq_pending | output | 1 | Interrupt-status bit |
| acc_error | output | 1 | Sticky error bit |

## Verification
The bench builds the block with its default parameters:
- `CAP_RST` = 2'b11, so the reset status byte is 0x60. Clearing both capability bits through status writes is therefore visible.
- `PTR_LSB_ZERO` = 2, so a pointer written with its low two bits set shows the masking both on readback and on the start pulse's pointer.

With these values every transition of the channel machine can be reached:
- FINISH while a HALT is being written in the same cycle;
- a halt refused because no device is attached;
- a launch refused for the same reason.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int WIN_BYTES = 8;
    localparam int OFF_W     = $clog2(WIN_BYTES);
    localparam int BUS_BYTES = 4;
    localparam int BUS_W     = 8 * BUS_BYTES;

    localparam logic [OFF_W-1:0] OFF_CMD = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STS = 3'd2;
    localparam logic [OFF_W-1:0] OFF_PTR = 3'd4;

    localparam int STS_ACT = 0;
    localparam int STS_ERR = 1;
    localparam int STS_IRQ = 2;
    localparam int CMD_GO  = 0;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic {
        CH_IDLE = 1'b0,
        CH_BUSY = 1'b1
    } ch_state_e;

    function automatic logic [2:0] size_bytes(input logic [1:0] sz);
        case (sz)
            SZ_BYTE: size_bytes = 3'd1;
            SZ_HALF: size_bytes = 3'd2;
            SZ_WORD: size_bytes = 3'd4;
            default: size_bytes = 3'd0;
        endcase
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
(
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic [1:0]       acc_size,
    input  logic [OFF_W-1:0] acc_offset,
    output logic             wr_cmd,
    output logic             wr_sts,
    output logic             wr_ptr,
    output logic             wr_bad
);
    logic is_wr;

    always_comb begin
        is_wr  = acc_valid && acc_write;
        wr_cmd = is_wr && (acc_offset == OFF_CMD) && (acc_size == SZ_BYTE);
        wr_sts = is_wr && (acc_offset == OFF_STS) && (acc_size == SZ_BYTE);
        wr_ptr = is_wr && (acc_offset == OFF_PTR) && (acc_size == SZ_WORD);
        wr_bad = is_wr && !(wr_cmd || wr_sts || wr_ptr);
    end

    // R2: at most one register strobe, and an error excludes any strobe
    always_comb begin
        if (acc_valid) begin
            p_one_target_r2: assert ($countones({wr_cmd, wr_sts, wr_ptr, wr_bad}) <= 1);
        end
    end
endmodule

// File: rtl/bmdma_ptr.sv
module bmdma_ptr
    import bmdma_pkg::*;
#(
    parameter int PTR_LSB_ZERO = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_ptr,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] ptr
);
    localparam logic [BUS_W-1:0] KEEP_MASK = ~((BUS_W'(1) << PTR_LSB_ZERO) - BUS_W'(1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (wr_ptr) begin
            ptr <= wdata & KEEP_MASK;
        end
    end

    p_ptr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ptr |=> (ptr[PTR_LSB_ZERO-1:0] == '0) &&
                   (ptr[BUS_W-1:PTR_LSB_ZERO] == $past(wdata[BUS_W-1:PTR_LSB_ZERO])));
endmodule

// File: rtl/bmdma_ctrl.sv
module bmdma_ctrl
    import bmdma_pkg::*;
#(
    parameter logic [1:0] CAP_RST = 2'b11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmd,
    input  logic             wr_sts,
    input  logic             wr_bad,
    input  logic [7:0]       wbyte,
    input  logic             dev_present,
    input  logic             dma_done,
    input  logic [BUS_W-1:0] ptr,
    output logic [7:0]       cmd_byte,
    output logic [7:0]       sts_byte,
    output logic             dma_start,
    output logic             dma_abort,
    output logic [BUS_W-1:0] start_ptr,
    output logic             busy
);
    localparam logic [4:0] MISC_RST = {1'b0, CAP_RST, 2'b00};

    ch_state_e  st, st_n;
    logic       ev_start, ev_abort, ev_nodev;
    logic [6:0] cmd_hi;
    logic [4:0] sts_misc;
    logic       sts_err, sts_irq;

    // next state: LAUNCH, HALT, FINISH
    always_comb begin
        st_n     = st;
        ev_start = 1'b0;
        ev_abort = 1'b0;
        ev_nodev = 1'b0;
        unique case (st)
            CH_IDLE: begin
                if (!dma_done && wr_cmd && wbyte[CMD_GO]) begin
                    if (dev_present) begin
                        st_n     = CH_BUSY;
                        ev_start = 1'b1;
                    end else begin
                        ev_nodev = 1'b1;
                    end
                end
            end
            CH_BUSY: begin
                if (dma_done) begin
                    st_n = CH_IDLE;
                end else if (wr_cmd && !wbyte[CMD_GO]) begin
                    if (dev_present) begin
                        st_n     = CH_IDLE;
                        ev_abort = 1'b1;
                    end else begin
                        ev_nodev = 1'b1;
                    end
                end
            end
            default: st_n = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= CH_IDLE;
        else        st <= st_n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_start <= 1'b0;
            dma_abort <= 1'b0;
            start_ptr <= '0;
            cmd_hi    <= '0;
            sts_misc  <= MISC_RST;
            sts_err   <= 1'b0;
            sts_irq   <= 1'b0;
        end else begin
            dma_start <= ev_start;
            dma_abort <= ev_abort;
            if (ev_start) start_ptr <= ptr;
            if (wr_cmd)   cmd_hi    <= wbyte[7:1];
            if (wr_sts)   sts_misc  <= wbyte[7:3];
            if (wr_bad || ev_nodev)               sts_err <= 1'b1;
            else if (wr_sts && wbyte[STS_ERR])    sts_err <= 1'b0;
            if (dma_done)                         sts_irq <= 1'b1;
            else if (wr_sts && wbyte[STS_IRQ])    sts_irq <= 1'b0;
        end
    end

    always_comb begin
        busy     = (st == CH_BUSY);
        cmd_byte = {cmd_hi, busy};
        sts_byte = {sts_misc, sts_irq, sts_err, busy};
    end

    p_start_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> busy);
    p_pulse_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dma_start, dma_abort}));
    p_start_ptr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        dma_start |-> (start_ptr == ptr));
    p_abort_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dma_abort |-> !busy);
    p_act_ro_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sts && !dma_done) |=> (busy == $past(busy)));
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_byte[STS_ERR] && !(wr_sts && wbyte[STS_ERR])) |=> sts_byte[STS_ERR]);
    p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done |=> (sts_byte[STS_IRQ] && !busy && !dma_start));
    p_nodev_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cmd && !dev_present) |=> (!dma_start && !dma_abort && busy == $past(busy)));
endmodule

// File: rtl/bmdma_readmux.sv
module bmdma_readmux
    import bmdma_pkg::*;
(
    input  logic [7:0]       cmd_byte,
    input  logic [7:0]       sts_byte,
    input  logic [BUS_W-1:0] ptr,
    input  logic [OFF_W-1:0] acc_offset,
    input  logic [1:0]       acc_size,
    output logic [BUS_W-1:0] rdata
);
    logic [7:0] win [WIN_BYTES];
    logic [2:0] nb;

    always_comb begin
        for (int i = 0; i < WIN_BYTES; i++) win[i] = 8'h00;
        win[OFF_CMD] = cmd_byte;
        win[OFF_STS] = sts_byte;
        for (int i = 0; i < BUS_BYTES; i++) win[OFF_PTR + i] = ptr[8*i +: 8];
        nb = size_bytes(acc_size);
    end

    for (genvar lane = 0; lane < BUS_BYTES; lane++) begin : g_lane
        localparam logic [OFF_W:0] LN = (OFF_W+1)'(lane);
        logic [OFF_W:0] idx;
        logic           on;
        always_comb begin
            idx = {1'b0, acc_offset} + LN;
            on  = (3'(lane) < nb) && (idx < (OFF_W+1)'(WIN_BYTES));
            rdata[8*lane +: 8] = on ? win[idx[OFF_W-1:0]] : 8'h00;
        end
    end
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter logic [1:0] CAP_RST      = 2'b11,
    parameter int         PTR_LSB_ZERO = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_valid,
    input  logic        acc_write,
    input  logic [1:0]  acc_size,
    input  logic [2:0]  acc_offset,
    input  logic [31:0] acc_wdata,
    output logic [31:0] acc_rdata,
    input  logic        dev_present,
    input  logic        dma_done,
    output logic        dma_start,
    output logic [31:0] dma_start_ptr,
    output logic        dma_abort,
    output logic        dma_active,
    output logic        irq_pending,
    output logic        acc_error
);
    logic             wr_cmd, wr_sts, wr_ptr, wr_bad;
    logic [BUS_W-1:0] ptr;
    logic [7:0]       cmd_byte, sts_byte;
    logic             busy;

    bmdma_decode u_decode (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_size  (acc_size),
        .acc_offset(acc_offset),
        .wr_cmd    (wr_cmd),
        .wr_sts    (wr_sts),
        .wr_ptr    (wr_ptr),
        .wr_bad    (wr_bad)
    );

    bmdma_ptr #(.PTR_LSB_ZERO(PTR_LSB_ZERO)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_ptr(wr_ptr),
        .wdata (acc_wdata),
        .ptr   (ptr)
    );

    bmdma_ctrl #(.CAP_RST(CAP_RST)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_cmd     (wr_cmd),
        .wr_sts     (wr_sts),
        .wr_bad     (wr_bad),
        .wbyte      (acc_wdata[7:0]),
        .dev_present(dev_present),
        .dma_done   (dma_done),
        .ptr        (ptr),
        .cmd_byte   (cmd_byte),
        .sts_byte   (sts_byte),
        .dma_start  (dma_start),
        .dma_abort  (dma_abort),
        .start_ptr  (dma_start_ptr),
        .busy       (busy)
    );

    bmdma_readmux u_rmux (
        .cmd_byte  (cmd_byte),
        .sts_byte  (sts_byte),
        .ptr       (ptr),
        .acc_offset(acc_offset),
        .acc_size  (acc_size),
        .rdata     (acc_rdata)
    );

    always_comb begin
        dma_active  = sts_byte[STS_ACT];
        irq_pending = sts_byte[STS_IRQ];
        acc_error   = sts_byte[STS_ERR];
    end

    // R11: mirrored outputs track the command start bit
    p_active_mirror_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_active == cmd_byte[CMD_GO]);
endmodule

// File: tb/bmdma_regs_tb.sv
module bmdma_regs_tb;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [1:0]  acc_size = 2'd0;
    logic [2:0]  acc_offset = 3'd0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        dev_present = 1'b1, dma_done = 1'b0;
    logic        dma_start, dma_abort, dma_active, irq_pending, acc_error;
    logic [31:0] dma_start_ptr;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    typedef struct { bit is_start; logic [31:0] ptr; } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bmdma_regs u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_size(acc_size), .acc_offset(acc_offset), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .dev_present(dev_present), .dma_done(dma_done),
        .dma_start(dma_start), .dma_start_ptr(dma_start_ptr), .dma_abort(dma_abort),
        .dma_active(dma_active), .irq_pending(irq_pending), .acc_error(acc_error)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic push(input bit is_start, input logic [31:0] p);
        exp_t e;
        e.is_start = is_start;
        e.ptr = p;
        expq.push_back(e);
    endtask

    // monitor: pops the scoreboard on every pulse
    always @(negedge clk) begin
        if (rst_n && (dma_start || dma_abort)) begin
            if (expq.size() == 0) begin
                chk("R3/R4/R10 unexpected pulse", {30'd0, dma_start, dma_abort}, 32'd0);
            end else begin
                exp_t e;
                e = expq.pop_front();
                chk("R3 R4 pulse kind", {31'd0, dma_start}, {31'd0, e.is_start});
                if (e.is_start) chk("R3 start ptr", dma_start_ptr, e.ptr);
            end
        end
    end

    task automatic wr(input logic [2:0] off, input logic [1:0] sz, input logic [31:0] d);
        acc_valid = 1'b1; acc_write = 1'b1; acc_offset = off; acc_size = sz; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic rd(input logic [2:0] off, input logic [1:0] sz, output logic [31:0] d);
        acc_valid = 1'b1; acc_write = 1'b0; acc_offset = off; acc_size = sz;
        #1 d = acc_rdata;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic rchk(input string req, input logic [2:0] off, input logic [1:0] sz,
                        input logic [31:0] exp);
        logic [31:0] d;
        rd(off, sz, d);
        chk(req, d, exp);
    endtask

    task automatic pulse_done();
        dma_done = 1'b1;
        @(negedge clk);
        dma_done = 1'b0;
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rchk("R1 status", 3'd2, 2'd0, 32'h60);
        rchk("R1 command", 3'd0, 2'd0, 32'h00);
        rchk("R1 pointer", 3'd4, 2'd2, 32'h0);
        chk("R1 no pulse", {30'd0, dma_start, dma_abort}, 32'd0);

        // R8 pointer alignment, R9 read formatting
        wr(3'd4, 2'd2, 32'h1234_5677);
        rchk("R8 pointer", 3'd4, 2'd2, 32'h1234_5674);
        rchk("R9 byte", 3'd4, 2'd0, 32'h74);
        rchk("R9 half", 3'd5, 2'd1, 32'h3456);
        rchk("R9 past window", 3'd6, 2'd2, 32'h0000_1234);
        rchk("R9 word at 0", 3'd0, 2'd2, 32'h0060_0000);
        rchk("R9 reserved", 3'd3, 2'd0, 32'h0);
        rchk("R9 bad size", 3'd0, 2'd3, 32'h0);

        // R2 illegal writes
        wr(3'd4, 2'd1, 32'hFFFF);
        rchk("R2 err set", 3'd2, 2'd0, 32'h62);
        rchk("R2 ptr kept", 3'd4, 2'd2, 32'h1234_5674);
        chk("R11 acc_error", {31'd0, acc_error}, 32'd1);
        wr(3'd2, 2'd0, 32'h62);
        rchk("R6 err cleared", 3'd2, 2'd0, 32'h60);
        wr(3'd1, 2'd0, 32'hFF);
        rchk("R2 reserved write err", 3'd2, 2'd0, 32'h62);
        rchk("R2 cmd kept", 3'd0, 2'd0, 32'h00);
        wr(3'd2, 2'd0, 32'h62);

        // R10 launch without device
        dev_present = 1'b0;
        wr(3'd0, 2'd0, 32'h01);
        rchk("R10 cmd", 3'd0, 2'd0, 32'h00);
        rchk("R10 err", 3'd2, 2'd0, 32'h62);
        wr(3'd2, 2'd0, 32'h62);
        dev_present = 1'b1;

        // R3 launch
        push(1'b1, 32'h1234_5674);
        wr(3'd0, 2'd0, 32'h09);
        rchk("R3 cmd", 3'd0, 2'd0, 32'h09);
        rchk("R3 active", 3'd2, 2'd0, 32'h61);
        chk("R11 dma_active", {31'd0, dma_active}, 32'd1);

        // R5 active read-only
        wr(3'd2, 2'd0, 32'h60);
        rchk("R5 busy keep", 3'd2, 2'd0, 32'h61);

        // R4 halt
        push(1'b0, 32'h0);
        wr(3'd0, 2'd0, 32'h08);
        rchk("R4 cmd", 3'd0, 2'd0, 32'h08);
        rchk("R4 status", 3'd2, 2'd0, 32'h60);
        wr(3'd2, 2'd0, 32'h61);
        rchk("R5 idle keep", 3'd2, 2'd0, 32'h60);

        // R7 finish
        wr(3'd4, 2'd2, 32'hA5A5_0003);
        push(1'b1, 32'hA5A5_0000);
        wr(3'd0, 2'd0, 32'h01);
        pulse_done();
        rchk("R7 cmd", 3'd0, 2'd0, 32'h00);
        rchk("R7 status", 3'd2, 2'd0, 32'h64);
        chk("R11 irq", {31'd0, irq_pending}, 32'd1);
        wr(3'd2, 2'd0, 32'h60);
        rchk("R6 write0 keeps irq", 3'd2, 2'd0, 32'h64);
        wr(3'd2, 2'd0, 32'h64);
        rchk("R6 irq cleared", 3'd2, 2'd0, 32'h60);

        // R7 precedence over same-cycle halt
        push(1'b1, 32'hA5A5_0000);
        wr(3'd0, 2'd0, 32'h01);
        dma_done = 1'b1;
        wr(3'd0, 2'd0, 32'h00);
        dma_done = 1'b0;
        rchk("R7 done vs halt cmd", 3'd0, 2'd0, 32'h00);
        rchk("R7 done vs halt sts", 3'd2, 2'd0, 32'h64);
        dma_done = 1'b1;
        wr(3'd2, 2'd0, 32'h64);
        dma_done = 1'b0;
        rchk("R7 done vs irq clear", 3'd2, 2'd0, 32'h64);
        wr(3'd2, 2'd0, 32'h64);

        // R6/R11 stored bits
        wr(3'd2, 2'd0, 32'h98);
        rchk("R6 misc bits", 3'd2, 2'd0, 32'h98);
        wr(3'd0, 2'd0, 32'hF0);
        rchk("R11 cmd bits idle", 3'd0, 2'd0, 32'hF0);

        // R10 halt without device
        push(1'b1, 32'hA5A5_0000);
        wr(3'd0, 2'd0, 32'h01);
        dev_present = 1'b0;
        wr(3'd0, 2'd0, 32'h00);
        rchk("R10 stay busy", 3'd0, 2'd0, 32'h01);
        rchk("R10 halt err", 3'd2, 2'd0, 32'h9B);
        dev_present = 1'b1;
        pulse_done();
        rchk("R7 final", 3'd2, 2'd0, 32'h9E);

        repeat (2) @(negedge clk);
        chk("R3/R4 scoreboard drained", expq.size(), 32'd0);
        finish_run();
    end
endmodule